// File: doc/BRIEF.md
# Supervisory Reset Generator with Manual Reset

This block produces one active-low system reset from two sources. The first is a supply-good flag from an external threshold comparator. The second is a pushbutton manual-reset line that idles high. Either source going bad pulls the reset low. The reset is released only after both sources have stayed good without a break for a programmable hold time, counted from whichever source recovered last.

Both inputs first pass through two-flop synchronizers. Each source then has its own run-length filter, so a supply dip or a button bounce shorter than its filter length is ignored. A loopback mode, chosen by a static input, feeds an active-low watchdog fault pulse into the manual path, so that a short fault pulse gives a full-length reset. All times are parameters counted in clock ticks. The defaults assume a 125 MHz clock: 180 ms hold, 1 µs manual filter and 20 µs supply filter. A status output, high while reset is asserted, can hold a watchdog quiet.

Top module: `sys_reset_gen`

## Requirements
- R1: While `arst_n` is low, and on the first cycle after it goes high, `rst_n` is 0. `rst_busy` is always the inverse of `rst_n`.
- R2: If `pwr_ok` is held at 0 for at least `PWR_FILT` consecutive cycles, `rst_n` goes to 0. The synchronizer adds 2 cycles and the filter adds `PWR_FILT` cycles.
- R3: If `pwr_ok` drops to 0 for fewer than `PWR_FILT` consecutive cycles, `rst_n` is not affected.
- R4: If the manual request (`mr_n` = 0, or the loopback request) is held for at least `MR_FILT` consecutive cycles, `rst_n` goes to 0.
- R5: A manual request shorter than `MR_FILT` cycles is rejected, and `rst_n` stays 1.
- R6: `rst_n` returns to 1 only after `HOLD_CYC` consecutive cycles in which neither filtered source signals a fault. The count starts from the later of the two releases.
- R7: A new filtered fault from either source during the hold countdown drives `rst_n` to 0 at once and restarts the count from zero.
- R8: When `loop_en` = 1, `wd_fault_n` = 0 acts exactly like `mr_n` = 0. When `loop_en` = 0, `wd_fault_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| pwr_ok | input | 1 | Supply-good flag from the comparator, 1 = good |
| mr_n | input | 1 | Manual reset button, active low, idles high |
| wd_fault_n | input | 1 | Watchdog fault pulse, active low |
| loop_en | input | 1 | 1 = route the watchdog fault into the manual path |
| rst_n | output | 1 | System reset, active low |
| rst_busy | output | 1 | Reset status, 1 while reset is asserted |

## Verification
The bench drives pulses exactly one cycle shorter than a filter length and exactly at that length. A filter with an off-by-one error would either let a one-cycle-short bounce reset the system or swallow a press of legal length. It releases the two sources at different times. A design that starts the hold count from the first release would free the reset too early. It also injects a supply fault partway through a hold countdown. A design that did not restart the count would release the reset before the full hold time had passed. The loopback is exercised with `loop_en` both set and clear, which catches a watchdog pulse that leaks through when loopback is off.

// File: rtl/sys_reset_gen.sv
module sys_reset_gen #(
  parameter int HOLD_CYC = 22_500_000,
  parameter int MR_FILT  = 125,
  parameter int PWR_FILT = 2500
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pwr_ok,
  input  logic mr_n,
  input  logic wd_fault_n,
  input  logic loop_en,
  output logic rst_n,
  output logic rst_busy
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int MW = $clog2(MR_FILT + 1);
  localparam int PW = $clog2(PWR_FILT + 1);
  localparam logic [HW-1:0] HOLD_TOP = HW'(HOLD_CYC);
  localparam logic [MW-1:0] MR_TOP   = MW'(MR_FILT);
  localparam logic [PW-1:0] PWR_TOP  = PW'(PWR_FILT);

  logic [1:0]    pwr_sy, mr_sy;
  logic [PW-1:0] pwr_cnt;
  logic [MW-1:0] mr_cnt;
  logic [HW-1:0] hold_cnt;
  logic          mr_raw, fault;

  assign mr_raw = mr_n & ~(loop_en & ~wd_fault_n);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      pwr_sy <= 2'b00;
      mr_sy  <= 2'b11;
    end else begin
      pwr_sy <= {pwr_sy[0], pwr_ok};
      mr_sy  <= {mr_sy[0], mr_raw};
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              pwr_cnt <= PWR_TOP;
    else if (pwr_sy[1])       pwr_cnt <= '0;
    else if (pwr_cnt != PWR_TOP) pwr_cnt <= pwr_cnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              mr_cnt <= '0;
    else if (mr_sy[1])        mr_cnt <= '0;
    else if (mr_cnt != MR_TOP) mr_cnt <= mr_cnt + 1'b1;

  assign fault = (pwr_cnt == PWR_TOP) | (mr_cnt == MR_TOP);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                 hold_cnt <= '0;
    else if (fault)              hold_cnt <= '0;
    else if (hold_cnt != HOLD_TOP) hold_cnt <= hold_cnt + 1'b1;

  assign rst_n    = ~fault & (hold_cnt == HOLD_TOP);
  assign rst_busy = ~rst_n;
endmodule

// File: rtl/sys_reset_gen_chk.sv
module sys_reset_gen_chk #(
  parameter int HOLD_CYC = 16,
  parameter int MR_FILT  = 4,
  parameter int PWR_FILT = 4,
  parameter int HW       = 5
) (
  input logic          clk,
  input logic          arst_n,
  input logic          pwr_ok,
  input logic          mr_raw,
  input logic          fault,
  input logic [HW-1:0] hold_cnt,
  input logic          rst_n
);
  int pwr_low, mr_low, quiet;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      pwr_low <= 0; mr_low <= 0; quiet <= 0;
    end else begin
      pwr_low <= pwr_ok ? 0 : (pwr_low < PWR_FILT + 8 ? pwr_low + 1 : pwr_low);
      mr_low  <= mr_raw ? 0 : (mr_low < MR_FILT + 8 ? mr_low + 1 : mr_low);
      quiet   <= fault ? 0 : (quiet < HOLD_CYC + 8 ? quiet + 1 : quiet);
    end

  // R1
  por_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(arst_n) |-> !rst_n);
  // R2
  pwr_fault_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_low >= PWR_FILT + 3) |-> !rst_n);
  // R4
  mr_fault_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mr_low >= MR_FILT + 3) |-> !rst_n);
  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> (quiet >= HOLD_CYC));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    fault |=> (hold_cnt == '0));
endmodule

bind sys_reset_gen sys_reset_gen_chk #(
  .HOLD_CYC(HOLD_CYC), .MR_FILT(MR_FILT), .PWR_FILT(PWR_FILT), .HW(HW)
) chk_i (
  .clk(clk), .arst_n(arst_n), .pwr_ok(pwr_ok), .mr_raw(mr_raw),
  .fault(fault), .hold_cnt(hold_cnt), .rst_n(rst_n)
);

// File: tb/sys_reset_gen_tb_top.sv
module sys_reset_gen_tb_top;
  localparam int HOLD = 40;
  localparam int MRF  = 8;
  localparam int PWF  = 12;

  logic clk = 1'b0;
  logic arst_n = 1'b0, pwr_ok = 1'b0, mr_n = 1'b1, wd_fault_n = 1'b1, loop_en = 1'b0;
  logic rst_n, rst_busy;
  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sys_reset_gen #(.HOLD_CYC(HOLD), .MR_FILT(MRF), .PWR_FILT(PWF)) dut_i (
    .clk(clk), .arst_n(arst_n), .pwr_ok(pwr_ok), .mr_n(mr_n),
    .wd_fault_n(wd_fault_n), .loop_en(loop_en), .rst_n(rst_n), .rst_busy(rst_busy));

  // behavioural reference: 2-cycle input delay, run lengths, quiet-time count
  int  pq[$], mq[$];
  int  prun, mrun, grun;
  bit  mfault, exp_n;

  always @(posedge clk) begin
    if (!arst_n) begin
      pq = {0, 0}; mq = {1, 1};
      prun = PWF; mrun = 0; grun = 0; mfault = 1; exp_n = 0;
    end else begin
      int pv, mv;
      pq.push_back(int'(pwr_ok));
      mq.push_back(int'(mr_n && !(loop_en && !wd_fault_n)));
      pv = pq.pop_front();
      mv = mq.pop_front();
      grun = mfault ? 0 : (grun < HOLD ? grun + 1 : grun);
      prun = pv ? 0 : (prun < PWF ? prun + 1 : prun);
      mrun = mv ? 0 : (mrun < MRF ? mrun + 1 : mrun);
      mfault = (prun >= PWF) || (mrun >= MRF);
      exp_n = !mfault && (grun >= HOLD);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rst_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (arst_n) begin
    chk(cur_req, rst_n, exp_n);
    chk("R1", rst_busy, ~exp_n);
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pwr_dip(input int n);
    pwr_ok = 1'b0; wait_cyc(n); pwr_ok = 1'b1;
  endtask

  task automatic mr_press(input int n);
    mr_n = 1'b0; wait_cyc(n); mr_n = 1'b1;
  endtask

  task automatic wd_pulse(input int n);
    wd_fault_n = 1'b0; wait_cyc(n); wd_fault_n = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    chk("R1", rst_n, 1'b0);
    arst_n = 1'b1;
    wait_cyc(1);
    chk("R1", rst_n, 1'b0);
    cur_req = "R6"; pwr_ok = 1'b1;
    wait_cyc(HOLD + 10);
    chk("R6", rst_n, 1'b1);

    cur_req = "R3";
    pwr_dip(5);       wait_cyc(20);
    pwr_dip(PWF - 1); wait_cyc(20);
    chk("R3", rst_n, 1'b1);

    cur_req = "R2";
    pwr_dip(PWF);     wait_cyc(HOLD + 10);
    pwr_dip(30);
    wait_cyc(3);
    chk("R2", rst_n, 1'b0);
    wait_cyc(HOLD + 10);
    chk("R2", rst_n, 1'b1);

    cur_req = "R5";
    mr_press(3);       wait_cyc(10);
    mr_press(MRF - 1); wait_cyc(10);
    chk("R5", rst_n, 1'b1);

    cur_req = "R4";
    mr_press(MRF);     wait_cyc(HOLD + 10);
    mr_press(20);      wait_cyc(HOLD + 10);
    chk("R4", rst_n, 1'b1);

    cur_req = "R7";
    mr_press(20); wait_cyc(20);
    pwr_dip(30);  wait_cyc(HOLD - 5);
    chk("R7", rst_n, 1'b0);
    wait_cyc(20);
    chk("R7", rst_n, 1'b1);

    cur_req = "R6";
    pwr_ok = 1'b0; mr_n = 1'b0; wait_cyc(20);
    pwr_ok = 1'b1; wait_cyc(25);
    mr_n = 1'b1;   wait_cyc(HOLD - 5);
    chk("R6", rst_n, 1'b0);
    wait_cyc(20);
    chk("R6", rst_n, 1'b1);

    cur_req = "R8";
    loop_en = 1'b0; wd_pulse(20); wait_cyc(20);
    chk("R8", rst_n, 1'b1);
    loop_en = 1'b1; wd_pulse(3);  wait_cyc(20);
    chk("R8", rst_n, 1'b1);
    wd_pulse(20); wait_cyc(2);
    chk("R8", rst_n, 1'b0);
    wait_cyc(HOLD + 10);
    chk("R8", rst_n, 1'b1);
    loop_en = 1'b0;

    wait_cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule